// File: doc/BRIEF.md
# Per-Pin Input Debouncer with Dual-Edge Events

This block conditions one pad input. The raw level first passes through a two-stage synchronizer. The synchronized level is then looked at only on a periodic check tick. A held (debounced) level moves to a new value only when the new value has been seen on a set number of consecutive ticks. Each direction has its own settle count. Any tick whose sample agrees with the held level reloads the count for the direction away from that level. As a result, a glitch shorter than the settle window leaves no trace.

The block also builds dual-edge detection out of single-edge hardware. A polarity bit is flipped after each accepted transition, so the next opposite edge is always armed. After reset, the block waits for the synchronizer to fill. It then takes the current level as its held state and sets the polarity to match that level. No event can fire before that capture.

When debouncing is switched off, the synchronized level is followed directly. In that mode, if dual-edge operation is enabled, every edge flips the polarity and pulses an event at once.

Top module: `pin_debouncer`

## Requirements
- R1: The raw input reaches the sampling logic through exactly two clocked stages. With debounce off and dual-edge on, a raw change made before clock edge k gives an event in the cycle that follows edge k+2, and no event after edge k or after edge k+1.
- R2: While `rst` is high, the held level, the polarity and the event output are all 0. The reported `level` is then 0 when `active_low` is 0.
- R3: After reset is released, the held level and the polarity both take the synchronized raw level on the third clock edge. This initialization fires no event.
- R4: With debounce on, a low-to-high change commits only on the LH_TICKS-th consecutive tick whose sample is high. The default is 2 ticks, from a 2 ms settle time over a 1 ms check period.
- R5: With debounce on, a high-to-low change commits only on the HL_TICKS-th consecutive tick whose sample is low. The default is 2 ticks.
- R6: A tick whose sample equals the held level reloads the counter. A later change then needs the full count again. The counter never exceeds the larger of the two reload values.
- R7: Every committed change of the held level inverts `polarity`. Every event coincides with a polarity inversion.
- R8: A committed change pulses `event_pulse` when any of these holds: `dual_edge` is 1; `active_low` is 1 and the new level is low; `active_low` is 0 and the new level is high. In every other case no event is produced, and no event is produced without a change of the held level.
- R9: An event from the debounced path lasts exactly one clock cycle.
- R10: `level` equals the held level, inverted when `active_low` is 1.
- R11: With `debounce_en` 0 and `dual_edge` 1, every change of the synchronized level inverts `polarity` and pulses `event_pulse`, with no tick needed.
- R12: No event fires from reset until initialization has been done.
- R13: With debounce on, the held level changes only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle check-period strobe |
| raw_in | input | 1 | Asynchronous pad level |
| active_low | input | 1 | Active level of the pin is low |
| dual_edge | input | 1 | Fire events on both edges |
| debounce_en | input | 1 | 1: filter on ticks; 0: follow synchronized level |
| level | output | 1 | Logical value: held level xor active_low |
| polarity | output | 1 | Edge-arming polarity bit |
| event_pulse | output | 1 | One-cycle event strobe |

## Verification
A wrong counter reload or a wrong decrement shows up as a commit one tick early or one tick late. That is visible on `level` and `polarity` in the cycle just after the offending tick. A polarity bit that falls out of step with the held level is caught by the next event, which must coincide with a polarity flip. A wrong event qualification appears as a missing or extra one-cycle pulse in the same cycle as the commit. A wrong synchronizer depth shifts the immediate dual-edge event by one cycle.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_INIT = 2'd1,
        PH_RUN  = 2'd2
    } pdb_phase_e;

    typedef struct packed {
        logic level;
        logic pol;
        logic evt;
    } pdb_flags_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic fire_event(input logic dual, input logic act_low,
                                        input logic new_level);
        return dual | (act_low & ~new_level) | (~act_low & new_level);
    endfunction

endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pdb_init_seq.sv
module pdb_init_seq #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic init_pulse,
    output logic run
);
    import pdb_pkg::*;

    localparam int WCNT_W = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(STAGES - 1);

    pdb_phase_e        phase;
    logic [WCNT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WAIT;
            wcnt  <= '0;
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (wcnt == WAIT_LAST) phase <= PH_INIT;
                    else                   wcnt  <= wcnt + 1'b1;
                end
                PH_INIT: phase <= PH_RUN;
                default: phase <= PH_RUN;
            endcase
        end
    end

    assign init_pulse = (phase == PH_INIT);
    assign run        = (phase == PH_RUN);
endmodule

// File: rtl/pdb_filter.sv
module pdb_filter #(
    parameter int LH_TICKS = 2,
    parameter int HL_TICKS = 2,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_pulse,
    input  logic             run,
    input  logic             tick,
    input  logic             smp,
    input  logic             deb_en,
    input  logic             dual,
    input  logic             act_low,
    output pdb_pkg::pdb_flags_t flags,
    output logic [CNT_W-1:0] cnt
);
    import pdb_pkg::*;

    localparam logic [CNT_W-1:0] LH_RELOAD = CNT_W'(LH_TICKS);
    localparam logic [CNT_W-1:0] HL_RELOAD = CNT_W'(HL_TICKS);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    pdb_flags_t       nxt;
    logic [CNT_W-1:0] nxt_cnt;
    logic             differs;

    function automatic logic [CNT_W-1:0] away_from(input logic held);
        return held ? HL_RELOAD : LH_RELOAD;
    endfunction

    always_comb begin
        nxt     = flags;
        nxt.evt = 1'b0;
        nxt_cnt = cnt;
        differs = (smp != flags.level);
        if (init_pulse) begin
            nxt.level = smp;
            nxt.pol   = smp;
            nxt_cnt   = away_from(smp);
        end else if (run) begin
            if (deb_en) begin
                if (tick) begin
                    if (!differs) begin
                        nxt_cnt = away_from(flags.level);
                    end else if (cnt <= ONE) begin
                        nxt.level = smp;
                        nxt.pol   = ~flags.pol;
                        nxt.evt   = fire_event(dual, act_low, smp);
                        nxt_cnt   = away_from(smp);
                    end else begin
                        nxt_cnt = cnt - ONE;
                    end
                end
            end else begin
                nxt.level = smp;
                nxt_cnt   = away_from(smp);
                if (differs && dual) begin
                    nxt.pol = ~flags.pol;
                    nxt.evt = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            cnt   <= '0;
        end else begin
            flags <= nxt;
            cnt   <= nxt_cnt;
        end
    end
endmodule

// File: rtl/pin_debouncer.sv
module pin_debouncer #(
    parameter int CHECK_MS    = 1,
    parameter int SETTLE_LH_MS = 2,
    parameter int SETTLE_HL_MS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw_in,
    input  logic active_low,
    input  logic dual_edge,
    input  logic debounce_en,
    output logic level,
    output logic polarity,
    output logic event_pulse
);
    import pdb_pkg::*;

    localparam int LH_TICKS = SETTLE_LH_MS / CHECK_MS;
    localparam int HL_TICKS = SETTLE_HL_MS / CHECK_MS;
    localparam int CNT_MAX  = max_of(LH_TICKS, HL_TICKS);
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    logic             smp;
    logic             init_pulse;
    logic             run;
    pdb_flags_t       flags;
    logic [CNT_W-1:0] cnt;

    pdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (smp)
    );

    pdb_init_seq #(.STAGES(SYNC_STAGES)) u_init (
        .clk        (clk),
        .rst        (rst),
        .init_pulse (init_pulse),
        .run        (run)
    );

    pdb_filter #(
        .LH_TICKS (LH_TICKS),
        .HL_TICKS (HL_TICKS),
        .CNT_W    (CNT_W)
    ) u_filt (
        .clk        (clk),
        .rst        (rst),
        .init_pulse (init_pulse),
        .run        (run),
        .tick       (tick),
        .smp        (smp),
        .deb_en     (debounce_en),
        .dual       (dual_edge),
        .act_low    (active_low),
        .flags      (flags),
        .cnt        (cnt)
    );

    assign level       = flags.level ^ active_low;
    assign polarity    = flags.pol;
    assign event_pulse = flags.evt;
endmodule

// File: rtl/pin_debouncer_chk.sv
module pin_debouncer_chk #(
    parameter int CNT_W   = 2,
    parameter int CNT_MAX = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             deb_en,
    input logic             run,
    input logic             held,
    input logic             pol,
    input logic             evt,
    input logic [CNT_W-1:0] cnt
);
    AST_EVT_FLIPS_POL: assert property (@(posedge clk) disable iff (rst)
        evt |-> (pol != $past(pol)));                         // R7

    AST_EVT_MOVES_LEVEL: assert property (@(posedge clk) disable iff (rst)
        evt |-> (held != $past(held)));                       // R8

    AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (evt && $past(deb_en)) |-> $past(tick));              // R13

    AST_NO_EVT_PRE_INIT: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !evt);                                // R12

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CNT_MAX));                              // R6
endmodule

bind pin_debouncer pin_debouncer_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .deb_en (debounce_en),
    .run    (run),
    .held   (flags.level),
    .pol    (flags.pol),
    .evt    (flags.evt),
    .cnt    (cnt)
);

// File: tb/pin_debouncer_tb.sv
module pin_debouncer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LH = 2;
    localparam int HL = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, raw_in = 1'b1, active_low = 1'b0, dual_edge = 1'b0, debounce_en = 1'b1;
    logic level, polarity, event_pulse;

    int checks = 0, fails = 0;
    bit model_on = 1'b1;
    bit finished = 1'b0;

    // bench reference state
    logic m_s1 = 0, m_s2 = 0, m_held = 0, m_pol = 0, m_evt = 0;
    int   m_cnt = 0, m_wait = 0, m_phase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_debouncer u_dut (
        .clk(clk), .rst(rst), .tick(tick), .raw_in(raw_in),
        .active_low(active_low), .dual_edge(dual_edge), .debounce_en(debounce_en),
        .level(level), .polarity(polarity), .event_pulse(event_pulse)
    );

    function automatic int away(input logic h);
        return h ? HL : LH;
    endfunction

    function automatic logic want_evt(input logic d, input logic al, input logic nl);
        return d || (al && !nl) || (!al && nl);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic o_s2 = m_s2;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_held = 0; m_pol = 0; m_evt = 0;
            m_cnt = 0; m_wait = 0; m_phase = 0;
            return;
        end
        m_evt = 0;
        if (m_phase == 1) begin
            m_held = o_s2; m_pol = o_s2; m_cnt = away(o_s2);
        end else if (m_phase == 2) begin
            if (debounce_en) begin
                if (tick) begin
                    if (o_s2 == m_held) m_cnt = away(m_held);
                    else if (m_cnt <= 1) begin
                        m_held = o_s2; m_pol = !m_pol; m_cnt = away(o_s2);
                        m_evt = want_evt(dual_edge, active_low, o_s2);
                    end else m_cnt = m_cnt - 1;
                end
            end else begin
                if (o_s2 != m_held && dual_edge) begin m_pol = !m_pol; m_evt = 1; end
                m_held = o_s2; m_cnt = away(o_s2);
            end
        end
        if (m_phase == 0) begin
            if (m_wait == 1) m_phase = 1; else m_wait++;
        end else m_phase = 2;
        m_s2 = m_s1; m_s1 = raw_in;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (model_on) begin
            chk("R10 level vs model", level, m_held ^ active_low);
            chk("R7 polarity vs model", polarity, m_pol);
            chk("R8 event vs model", event_pulse, m_evt);
        end
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_tick();
        tick = 1'b1; cyc(); tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic p0;
        @(negedge clk);
        cycn(2);
        // R2 reset state
        chk("R2 level in reset", level, 1'b0);
        chk("R2 polarity in reset", polarity, 1'b0);
        chk("R2 event in reset", event_pulse, 1'b0);
        rst = 1'b0;
        cyc(); chk("R12 no event before init", event_pulse, 1'b0);
        cyc(); chk("R12 no event before init", event_pulse, 1'b0);
        cyc();
        chk("R3 init level", level, 1'b1);
        chk("R3 init polarity", polarity, 1'b1);
        chk("R3 init fires no event", event_pulse, 1'b0);
        // falling edge, debounced
        raw_in = 1'b0; cycn(4);
        chk("R13 no change without tick", level, 1'b1);
        do_tick(); chk("R5 one low tick holds", level, 1'b1);
        do_tick();
        chk("R5 fall commits on 2nd tick", level, 1'b0);
        chk("R7 polarity flips on fall", polarity, 1'b0);
        chk("R8 no event on fall, active high", event_pulse, 1'b0);
        // rising edge
        raw_in = 1'b1; cycn(3);
        do_tick(); chk("R4 one high tick holds", level, 1'b0);
        do_tick();
        chk("R4 rise commits on 2nd tick", level, 1'b1);
        chk("R8 event on rise, active high", event_pulse, 1'b1);
        cyc(); chk("R9 event lasts one cycle", event_pulse, 1'b0);
        // glitch reload
        raw_in = 1'b0; cycn(3); do_tick();
        raw_in = 1'b1; cycn(3); do_tick();
        raw_in = 1'b0; cycn(3); do_tick();
        chk("R6 reload demands full count", level, 1'b1);
        do_tick(); chk("R6 commit after full count", level, 1'b0);
        // active low
        active_low = 1'b1; cyc();
        chk("R10 level inverted when active low", level, 1'b1);
        raw_in = 1'b1; cycn(3); do_tick(); do_tick();
        chk("R10 high held reads low", level, 1'b0);
        chk("R8 no event on rise, active low", event_pulse, 1'b0);
        raw_in = 1'b0; cycn(3); do_tick(); do_tick();
        chk("R8 event on fall, active low", event_pulse, 1'b1);
        // dual edge, debounced
        active_low = 1'b0; dual_edge = 1'b1;
        raw_in = 1'b1; cycn(3); do_tick(); do_tick();
        chk("R8 dual event on rise", event_pulse, 1'b1);
        raw_in = 1'b0; cycn(3); do_tick(); do_tick();
        chk("R8 dual event on fall", event_pulse, 1'b1);
        // no debounce, immediate dual edge
        debounce_en = 1'b0; cycn(2);
        p0 = polarity;
        raw_in = 1'b1;
        cyc(); chk("R1 no event after first stage", event_pulse, 1'b0);
        cyc(); chk("R1 no event after second stage", event_pulse, 1'b0);
        cyc();
        chk("R11 immediate event on edge", event_pulse, 1'b1);
        chk("R11 polarity flips on edge", polarity, ~p0);
        raw_in = 1'b0; cycn(3);
        chk("R11 immediate event on fall", event_pulse, 1'b1);
        chk("R11 polarity flips back", polarity, p0);
        // constrained random
        void'($urandom(32'd20240611));
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(5) == 0) raw_in = ~raw_in;
            tick = ($urandom_range(2) == 0);
            if ($urandom_range(299) == 0) active_low  = ~active_low;
            if ($urandom_range(299) == 0) dual_edge   = ~dual_edge;
            if ($urandom_range(399) == 0) debounce_en = ~debounce_en;
            cyc();
        end
        tick = 1'b0;
        finish_run();
    end
endmodule